// File: doc/BRIEF.md
# Address range chip-select decoder

This block sits at the front of a peripheral bus slave wrapper. It watches the address and select lines of an APB-style bus and works out three things for each transfer. First, whether the address belongs to this slave at all. Second, which of three configured address windows it falls in. Third, for the window that holds the software registers, which 32-bit register is addressed. The results are registered in the setup phase. They appear as one-cycle pulses in the access phase, where the register storage and other wrapper services use them as strobes.

The decode runs in three tiers, each with its own compare width. A field of high-order bits is common to every window and picks the device. A short field below it, sized for each window, picks the window. A word index inside the register window picks a register, and the byte-lane bits below that index are passed through. For reads, the block also steers the addressed register word from a flat register bank onto the read-data output, and it drives a single-cycle ready.

Top module: `apb_range_decoder`

## Requirements
- R1: In the cycle after a setup cycle (`psel`=1, `penable`=0), `devSel` is 1 exactly when address bits [31:19] are all zero. `devSel` is 0 in every other cycle. No window select is ever active while `devSel` is 0.
- R2: Window 0 spans 0x00000000–0x00003FFF. Its select, `rangeSel[0]`, pulses when the device matches and bits [18:14] equal 5'b00000.
- R3: Window 1 spans 0x00060000–0x0007FFFF. Its select, `rangeSel[1]`, pulses when the device matches and bits [18:17] equal 2'b11.
- R4: Window 2 spans 0x00010000–0x0001FFFF. Its select, `rangeSel[2]`, pulses when the device matches and bits [18:16] equal 3'b001. An address whose device bits match but which meets none of the three window fields raises no window select.
- R5: A read setup (`pwrite`=0) in window 0 pulses `rdCe[k]`, where k = address bits [5:2]. Address bits [13:6] do not take part, so such addresses alias. Window 1 and window 2 never raise a chip-enable.
- R6: A write setup (`pwrite`=1) in window 0 pulses `wrCe[k]`, with k = bits [5:2], and leaves `rdCe` at zero.
- R7: An index k of 10 to 15 in window 0 raises no bit of `rdCe` or `wrCe`, and a read of such an index returns `prdata` = 0.
- R8: For a valid read, `prdata` holds register word k of `regBank` (bits [32k+31:32k]) in the access cycle. In every other cycle `prdata` is 0.
- R9: In the access cycle, `laneIdx` equals address bits [1:0] of the setup cycle.
- R10: At most one bit of `rangeSel` is 1 in any cycle, and at most one bit of the combined `{rdCe, wrCe}` is 1.
- R11: After reset all outputs are 0. With `psel`=0, or with `penable`=1, no select, enable or ready is raised in the following cycle.
- R12: `pready` is 1 for exactly the one cycle after each setup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low synchronous reset |
| paddr | input | 32 | Bus address |
| psel | input | 1 | Slave select from the bus |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| regBank | input | 320 | Ten 32-bit register words; word k at bits [32k+31:32k] |
| devSel | output | 1 | Device matched, access-phase pulse |
| rangeSel | output | 3 | One select per address window |
| rdCe | output | 10 | One-hot read enable per register |
| wrCe | output | 10 | One-hot write enable per register |
| laneIdx | output | 2 | Byte-lane bits of the address |
| prdata | output | 32 | Read data of the addressed register, zero otherwise |
| pready | output | 1 | Single-cycle transfer ready |

## Verification
The bench targets the holes between windows, such as 0x00004000, 0x00020000 and 0x00040000. There the device bits match but no window field does. A decoder that compared too few field bits would raise a window select there, and one that tied window selects to a full-width compare would miss 0x0007FFFC. It also drives register indices 10 to 15 and addresses with bits [13:6] set. A decoder with an unguarded index compare would pulse a phantom enable or return stale data, and one that decoded the aliasing bits would drop valid registers. Cycles with `psel` low or `penable` high show whether strobes leak outside the access phase. Bit 19 set tests whether the shared device field is compared.

// File: rtl/ard_pkg.sv
package ard_pkg;

  // Strobes passed from the decode control to the registered datapath.
  typedef struct packed {
    logic capture;   // setup phase of a transfer
    logic devHit;    // shared high-order field matched
    logic rdStrobe;  // read inside the register window
    logic wrStrobe;  // write inside the register window
    logic idxOk;     // register index below the register count
  } decStrobe_t;

endpackage

// File: rtl/ard_ctrl.sv
module ard_ctrl
  import ard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEV_BITS   = 13,
  parameter int NUM_RANGES = 3,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_BASE =
    {32'h0001_0000, 32'h0006_0000, 32'h0000_0000},
  parameter logic [NUM_RANGES-1:0][7:0] RANGE_FIELD_W = {8'd3, 8'd2, 8'd5},
  parameter int REG_RANGE  = 0,
  parameter int NUM_REGS   = 10,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int LANE_W    = $clog2(DATA_W / 8)
) (
  input  logic                  clk,
  input  logic                  rstn,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  output decStrobe_t            strb,
  output logic [NUM_RANGES-1:0] rangeHit,
  output logic [IDX_W-1:0]      regIdx
);

  localparam int FIELD_TOP = ADDR_W - DEV_BITS - 1;

  logic                  devHit;
  logic [NUM_RANGES-1:0] fieldHit;
  logic                  capture;
  logic                  unusedAddrBits;

  // Tier 1: the high-order field shared by every window.
  assign devHit = (paddr[ADDR_W-1 -: DEV_BITS] == RANGE_BASE[0][ADDR_W-1 -: DEV_BITS]);

  // Tier 2: a short field per window, sized by its own parameter.
  for (genvar g = 0; g < NUM_RANGES; g++) begin : gen_field
    localparam int FLO = FIELD_TOP - int'(RANGE_FIELD_W[g]) + 1;
    assign fieldHit[g] = (paddr[FIELD_TOP:FLO] == RANGE_BASE[g][FIELD_TOP:FLO]);
  end

  assign rangeHit = devHit ? fieldHit : '0;

  // Tier 3: word index inside the register window.
  assign regIdx  = paddr[LANE_W +: IDX_W];
  assign capture = psel & ~penable;

  // Offset bits between the index and the window field do not take part.
  assign unusedAddrBits = ^paddr;

  always_comb begin
    strb          = '0;
    strb.capture  = capture;
    strb.devHit   = devHit;
    strb.idxOk    = (32'(regIdx) < NUM_REGS);
    strb.rdStrobe = capture & ~pwrite & rangeHit[REG_RANGE];
    strb.wrStrobe = capture &  pwrite & rangeHit[REG_RANGE];
  end

  AST_FIELDS_DISJOINT: assert property (@(posedge clk) disable iff (!rstn)
    psel |-> $onehot0(rangeHit)) else $error("window fields overlap"); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstn)
    !(strb.rdStrobe && strb.wrStrobe)) else $error("read and write strobe together"); // R6

endmodule

// File: rtl/ard_dpath.sv
module ard_dpath
  import ard_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_RANGES = 3,
  parameter int REG_RANGE  = 0,
  parameter int NUM_REGS   = 10,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int LANE_W    = $clog2(DATA_W / 8)
) (
  input  logic                       clk,
  input  logic                       rstn,
  input  decStrobe_t                 strb,
  input  logic [NUM_RANGES-1:0]      rangeHit,
  input  logic [IDX_W-1:0]           regIdx,
  input  logic [LANE_W-1:0]          laneIn,
  input  logic [NUM_REGS*DATA_W-1:0] regBank,
  output logic                       devSel,
  output logic [NUM_RANGES-1:0]      rangeSel,
  output logic [NUM_REGS-1:0]        rdCe,
  output logic [NUM_REGS-1:0]        wrCe,
  output logic [LANE_W-1:0]          laneIdx,
  output logic [DATA_W-1:0]          rdData,
  output logic                       ready
);

  logic [NUM_REGS-1:0] rdCeNext;
  logic [NUM_REGS-1:0] wrCeNext;
  logic [DATA_W-1:0]   selWord;
  logic                rdValid;

  // One enable per register, each a compare against its own index.
  for (genvar i = 0; i < NUM_REGS; i++) begin : gen_ce
    assign rdCeNext[i] = strb.rdStrobe & strb.idxOk & (regIdx == IDX_W'(i));
    assign wrCeNext[i] = strb.wrStrobe & strb.idxOk & (regIdx == IDX_W'(i));
  end

  assign rdValid = strb.rdStrobe & strb.idxOk;

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (regIdx == IDX_W'(i)) selWord = regBank[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstn) begin
      devSel   <= 1'b0;
      rangeSel <= '0;
      rdCe     <= '0;
      wrCe     <= '0;
      laneIdx  <= '0;
      rdData   <= '0;
      ready    <= 1'b0;
    end else begin
      devSel   <= strb.capture & strb.devHit;
      rangeSel <= strb.capture ? rangeHit : '0;
      rdCe     <= rdCeNext;
      wrCe     <= wrCeNext;
      if (strb.capture) laneIdx <= laneIn;
      rdData   <= rdValid ? selWord : '0;
      ready    <= strb.capture;
    end
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstn)
    $onehot0(rangeSel)) else $error("several window selects"); // R10

  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rstn)
    $onehot0({rdCe, wrCe})) else $error("several chip-enables"); // R10

  AST_CS_NEEDS_DEV: assert property (@(posedge clk) disable iff (!rstn)
    (|rangeSel) |-> devSel) else $error("window select without device"); // R1

  AST_CE_IN_REG_RANGE: assert property (@(posedge clk) disable iff (!rstn)
    (|{rdCe, wrCe}) |-> rangeSel[REG_RANGE]) else $error("enable outside register window"); // R5

  AST_DATA_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstn)
    (|rdData) |-> (|rdCe)) else $error("read data without read enable"); // R8

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstn)
    ready |=> !ready) else $error("ready longer than one cycle"); // R12

endmodule

// File: rtl/apb_range_decoder.sv
module apb_range_decoder
  import ard_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEV_BITS   = 13,
  parameter int NUM_RANGES = 3,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_BASE =
    {32'h0001_0000, 32'h0006_0000, 32'h0000_0000},
  parameter logic [NUM_RANGES-1:0][7:0] RANGE_FIELD_W = {8'd3, 8'd2, 8'd5},
  parameter int REG_RANGE  = 0,
  parameter int NUM_REGS   = 10,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int LANE_W    = $clog2(DATA_W / 8)
) (
  input  logic                       pclk,
  input  logic                       presetn,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [NUM_REGS*DATA_W-1:0] regBank,
  output logic                       devSel,
  output logic [NUM_RANGES-1:0]      rangeSel,
  output logic [NUM_REGS-1:0]        rdCe,
  output logic [NUM_REGS-1:0]        wrCe,
  output logic [LANE_W-1:0]          laneIdx,
  output logic [DATA_W-1:0]          prdata,
  output logic                       pready
);

  decStrobe_t            decStrb;
  logic [NUM_RANGES-1:0] rangeHit;
  logic [IDX_W-1:0]      regIdx;

  ard_ctrl #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .DEV_BITS      (DEV_BITS),
    .NUM_RANGES    (NUM_RANGES),
    .RANGE_BASE    (RANGE_BASE),
    .RANGE_FIELD_W (RANGE_FIELD_W),
    .REG_RANGE     (REG_RANGE),
    .NUM_REGS      (NUM_REGS)
  ) u_ctrl (
    .clk      (pclk),
    .rstn     (presetn),
    .paddr    (paddr),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .strb     (decStrb),
    .rangeHit (rangeHit),
    .regIdx   (regIdx)
  );

  ard_dpath #(
    .DATA_W     (DATA_W),
    .NUM_RANGES (NUM_RANGES),
    .REG_RANGE  (REG_RANGE),
    .NUM_REGS   (NUM_REGS)
  ) u_dpath (
    .clk      (pclk),
    .rstn     (presetn),
    .strb     (decStrb),
    .rangeHit (rangeHit),
    .regIdx   (regIdx),
    .laneIn   (paddr[LANE_W-1:0]),
    .regBank  (regBank),
    .devSel   (devSel),
    .rangeSel (rangeSel),
    .rdCe     (rdCe),
    .wrCe     (wrCe),
    .laneIdx  (laneIdx),
    .rdData   (prdata),
    .ready    (pready)
  );

endmodule

// File: tb/apb_range_decoder_tb.sv
`timescale 1ns/1ps
module apb_range_decoder_tb;

  logic         clk = 1'b0;
  logic         presetn;
  logic [31:0]  paddr;
  logic         psel, penable, pwrite;
  logic [319:0] regBank;
  logic         devSel;
  logic [2:0]   rangeSel;
  logic [9:0]   rdCe, wrCe;
  logic [1:0]   laneIdx;
  logic [31:0]  prdata;
  logic         pready;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  apb_range_decoder u_dut (
    .pclk(clk), .presetn(presetn), .paddr(paddr), .psel(psel),
    .penable(penable), .pwrite(pwrite), .regBank(regBank),
    .devSel(devSel), .rangeSel(rangeSel), .rdCe(rdCe), .wrCe(wrCe),
    .laneIdx(laneIdx), .prdata(prdata), .pready(pready)
  );

  function automatic logic [31:0] wordOf(int k);
    return 32'hA500_0000 | (32'(k) * 32'h0001_1111) | 32'h1;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic checkQuiet(input string tag);
    chk({tag, " R11 devSel quiet"}, 64'(devSel), 64'd0);
    chk({tag, " R11 rangeSel quiet"}, 64'(rangeSel), 64'd0);
    chk({tag, " R11 enables quiet"}, 64'({rdCe, wrCe}), 64'd0);
    chk({tag, " R11 pready quiet"}, 64'(pready), 64'd0);
    chk({tag, " R8 prdata quiet"}, 64'(prdata), 64'd0);
  endtask

  // One full transfer: setup, access, then idle; checks the access cycle
  // against a model built from the requirements and the next cycle for silence.
  task automatic access(input logic [31:0] a, input logic wr);
    logic       eDev;
    logic [2:0] eCs;
    logic [3:0] k;
    logic       ceOk;
    logic [9:0] eRd, eWr;
    logic [31:0] eData;
    eDev   = (a[31:19] == 13'd0);
    eCs[0] = eDev && (a[18:14] == 5'b00000);
    eCs[1] = eDev && (a[18:17] == 2'b11);
    eCs[2] = eDev && (a[18:16] == 3'b001);
    k      = a[5:2];
    ceOk   = eCs[0] && (k < 4'd10);
    eRd    = (!wr && ceOk) ? (10'd1 << k) : 10'd0;
    eWr    = ( wr && ceOk) ? (10'd1 << k) : 10'd0;
    eData  = (!wr && ceOk) ? wordOf(int'(k)) : 32'd0;
    @(negedge clk);
    paddr = a; pwrite = wr; psel = 1'b1; penable = 1'b0;
    @(negedge clk);
    chk($sformatf("R1 devSel @%08h", a), 64'(devSel), 64'(eDev));
    chk($sformatf("R2 R3 R4 rangeSel @%08h", a), 64'(rangeSel), 64'(eCs));
    chk($sformatf("R5 R7 rdCe @%08h", a), 64'(rdCe), 64'(eRd));
    chk($sformatf("R6 R7 wrCe @%08h", a), 64'(wrCe), 64'(eWr));
    chk($sformatf("R8 prdata @%08h", a), 64'(prdata), 64'(eData));
    chk($sformatf("R9 laneIdx @%08h", a), 64'(laneIdx), 64'(a[1:0]));
    chk($sformatf("R12 pready @%08h", a), 64'(pready), 64'd1);
    chk("R10 one window select", 64'($onehot0(rangeSel)), 64'd1);
    chk("R10 one chip-enable", 64'($onehot0({rdCe, wrCe})), 64'd1);
    penable = 1'b1;
    @(negedge clk);
    checkQuiet("after access");
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic testReset();
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
    repeat (3) @(negedge clk);
    checkQuiet("reset");
    presetn = 1'b1;
  endtask

  task automatic testRegReads();
    for (int k = 0; k < 10; k++) access(32'(k * 4), 1'b0);      // R5 R8
  endtask

  task automatic testRegWrites();
    for (int k = 0; k < 10; k++) access(32'(k * 4 + (k % 4)), 1'b1); // R6 R9
  endtask

  task automatic testHighIndex();
    for (int k = 10; k < 16; k++) begin
      access(32'(k * 4), 1'b0);                                   // R7
      access(32'(k * 4 + 3), 1'b1);                               // R7
    end
  endtask

  task automatic testAlias();
    access(32'h0000_1FC4, 1'b0);   // R5 bits [13:6] ignored -> index 1
    access(32'h0000_3FE4, 1'b1);   // R6 index 9 alias
  endtask

  task automatic testOtherWindows();
    access(32'h0006_0000, 1'b0);   // R3
    access(32'h0007_FFFC, 1'b1);   // R3 top of window
    access(32'h0001_0000, 1'b0);   // R4
    access(32'h0001_FFFF, 1'b1);   // R4 top, lane 3
  endtask

  task automatic testGaps();
    access(32'h0000_4000, 1'b0);   // R2 hole just above window 0
    access(32'h0002_0000, 1'b0);   // R4 hole
    access(32'h0004_0000, 1'b1);   // R3 hole
    access(32'h0008_0000, 1'b0);   // R1 bit 19 set
    access(32'hFFFF_0004, 1'b0);   // R1 far away
  endtask

  task automatic testIdle();
    @(negedge clk);
    paddr = 32'h0000_0008; pwrite = 1'b0; psel = 1'b0; penable = 1'b0;
    @(negedge clk);
    checkQuiet("idle psel low");                                  // R11
    penable = 1'b1;
    @(negedge clk);
    checkQuiet("penable without psel");                           // R11
    psel = 1'b1;
    @(negedge clk);
    checkQuiet("psel with penable high");                         // R11
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 10; k++) regBank[k*32 +: 32] = wordOf(k);
    testReset();
    testRegReads();
    testRegWrites();
    testHighIndex();
    testAlias();
    testOtherWindows();
    testGaps();
    testIdle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule